// File: doc/BRIEF.md
# Fractional-Rate SPI Serial Clock Generator

This block derives the serial clock of an SPI master from a fast reference clock. The rate comes from a phase accumulator, not an integer divider. Each enabled reference cycle adds a rate word to a 12-bit accumulator. When the sum reaches 2048, the serial clock changes level and the excess is kept for the next cycle. A rate word of 2048 therefore toggles the clock on every reference cycle. A smaller word gives an average rate of `f_ref * word / 4096`, and the edges follow a pattern that repeats over several reference cycles.

Alongside the clock pin, the block produces two strobes for a neighbouring shift register: one marks when to launch outgoing data and one marks when to capture incoming data. Each strobe lasts one reference cycle and is chosen independently to fire on rising or falling serial-clock edges. Further inputs set the idle level of the clock, double the effective rate word, and zero the accumulator when a transfer begins. A decoded output reports when the programmed rate is above a synchronous-capture limit, so that the capture logic can switch to its asynchronous input path.

Top module: `spi_phase_clkgen`

## Requirements
- R1: During and right after reset, `sclk` equals `cpol`, both strobes are low, and the accumulator is zero.
- R2: In each cycle with `enable` high and no clearing start, the effective increment is added to the accumulator. If the sum is 2048 or more, `sclk` toggles in the next cycle and the accumulator keeps the sum minus 2048; otherwise it keeps the sum. An effective increment above 2048 is treated as 2048.
- R3: With an effective increment of 2048, `sclk` toggles on every enabled reference cycle. With 512, starting from a zero accumulator, it toggles once every 4 cycles.
- R4: On a rising `sclk` edge, `launch_stb` is high for that single cycle if `launch_rise` is 1, and `sample_stb` is high if `latch_rise` is 1. On a falling edge, each strobe fires when its select is 0. A strobe is never high in a cycle where `sclk` did not change.
- R5: While `enable` is low, `sclk` sits at `cpol` from the next cycle on, no strobe fires, and the accumulator keeps its value.
- R6: A cycle with `start` and `acc_clear_on_start` both high zeroes the accumulator whatever `enable` is. That cycle adds nothing and produces no edge. `start` alone has no effect.
- R7: With `double_rate` high, the effective increment is twice `freq_word`, still limited to 2048.
- R8: `fast_path` is high exactly when effective increment × `REF_HZ` > `SYNC_LIMIT_HZ` × 4096, i.e. when the serial clock is faster than the synchronous-capture limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transfer active; clock runs while high |
| start | input | 1 | One-cycle pulse marking the start of a transfer |
| acc_clear_on_start | input | 1 | Zero the accumulator on `start` |
| double_rate | input | 1 | Double the effective increment |
| cpol | input | 1 | Idle level of `sclk` |
| launch_rise | input | 1 | 1: launch on rising edges, 0: on falling edges |
| latch_rise | input | 1 | 1: capture on rising edges, 0: on falling edges |
| freq_word | input | 16 | Rate word, 2048 = one toggle per reference cycle |
| sclk | output | 1 | Serial clock pin |
| launch_stb | output | 1 | One-cycle launch enable, aligned with the `sclk` edge |
| sample_stb | output | 1 | One-cycle capture enable, aligned with the `sclk` edge |
| fast_path | output | 1 | Rate exceeds the synchronous-capture limit |

## Verification
The delicate overlap is a clearing `start` that arrives in a cycle where the accumulator would overflow. The clear must win: no edge and no strobe that cycle, and the next edge is timed from zero. Random stimulus pulses `start` with the clear option on at arbitrary phases against rate words near 2048. Every cycle, a bench model that follows R2 and R6 predicts `sclk` and both strobes. A second overlap, an overflow in the same cycle that `enable` falls, is reached the same way. There the idle level must appear on the next cycle with no strobe.

// File: rtl/spi_phase_clkgen.sv
module spi_phase_clkgen #(
  parameter int FW_W          = 16,
  parameter int ACC_W         = 12,
  parameter int REF_HZ        = 200_000_000,
  parameter int SYNC_LIMIT_HZ = 30_000_000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            start,
  input  logic            acc_clear_on_start,
  input  logic            double_rate,
  input  logic            cpol,
  input  logic            launch_rise,
  input  logic            latch_rise,
  input  logic [FW_W-1:0] freq_word,
  output logic            sclk,
  output logic            launch_stb,
  output logic            sample_stb,
  output logic            fast_path
);
  localparam int          FULL     = 1 << (ACC_W - 1);
  localparam logic [63:0] FAST_THR = 64'(SYNC_LIMIT_HZ) << ACC_W;

  logic [FW_W:0]    raw_inc;
  logic [ACC_W-1:0] inc, acc;
  logic [ACC_W:0]   sum, rem;
  logic             wrap, clr, tick, ph, rising;

  assign raw_inc = double_rate ? {freq_word, 1'b0} : {1'b0, freq_word};
  assign inc     = (raw_inc > (FW_W+1)'(FULL)) ? ACC_W'(FULL) : raw_inc[ACC_W-1:0];
  assign sum     = {1'b0, acc} + {1'b0, inc};
  assign rem     = sum - (ACC_W+1)'(FULL);
  assign wrap    = sum >= (ACC_W+1)'(FULL);
  assign clr     = start & acc_clear_on_start;
  assign tick    = enable & ~clr & wrap;
  assign rising  = (ph == cpol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      ph         <= 1'b0;
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
    end else begin
      launch_stb <= 1'b0;
      sample_stb <= 1'b0;
      if (clr)
        acc <= '0;
      else if (enable)
        acc <= wrap ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
      if (!enable)
        ph <= 1'b0;
      else if (tick) begin
        ph         <= ~ph;
        launch_stb <= (rising == launch_rise);
        sample_stb <= (rising == latch_rise);
      end
    end
  end

  assign sclk      = ph ^ cpol;
  assign fast_path = (64'(inc) * 64'(REF_HZ)) > FAST_THR;
endmodule

// File: rtl/spi_phase_clkgen_chk.sv
module spi_phase_clkgen_chk #(
  parameter int FW_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            enable,
  input logic            start,
  input logic            acc_clear_on_start,
  input logic            double_rate,
  input logic            cpol,
  input logic            launch_rise,
  input logic            latch_rise,
  input logic [FW_W-1:0] freq_word,
  input logic            sclk,
  input logic            launch_stb,
  input logic            sample_stb,
  input logic            fast_path
);
  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (sclk == cpol) && !launch_stb && !sample_stb);

  // R4
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch_stb && $stable(cpol) |-> (sclk != $past(sclk)) && (sclk == $past(launch_rise)));

  // R4
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb && $stable(cpol) |-> (sclk != $past(sclk)) && (sclk == $past(latch_rise)));

  // R6
  clear_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start && acc_clear_on_start) |-> !launch_stb && !sample_stb);

  // R8
  fast_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(freq_word) && $stable(double_rate) |-> $stable(fast_path));
endmodule

bind spi_phase_clkgen spi_phase_clkgen_chk #(.FW_W(FW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
  .acc_clear_on_start(acc_clear_on_start), .double_rate(double_rate),
  .cpol(cpol), .launch_rise(launch_rise), .latch_rise(latch_rise),
  .freq_word(freq_word), .sclk(sclk), .launch_stb(launch_stb),
  .sample_stb(sample_stb), .fast_path(fast_path)
);

// File: tb/test_spi_phase_clkgen.sv
module test_spi_phase_clkgen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, start = 0, acc_clear_on_start = 0, double_rate = 0;
  logic cpol = 0, launch_rise = 0, latch_rise = 1;
  logic [15:0] freq_word = 16'd0;
  logic sclk, launch_stb, sample_stb, fast_path;

  int checks = 0, errors = 0, toggles = 0;
  logic prev_sclk = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_phase_clkgen i_spi_phase_clkgen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .acc_clear_on_start(acc_clear_on_start), .double_rate(double_rate),
    .cpol(cpol), .launch_rise(launch_rise), .latch_rise(latch_rise),
    .freq_word(freq_word), .sclk(sclk), .launch_stb(launch_stb),
    .sample_stb(sample_stb), .fast_path(fast_path));

  function automatic int eff_inc(input logic [15:0] w, input logic dbl);
    int v = dbl ? 2 * int'(w) : int'(w);
    return (v > 2048) ? 2048 : v;
  endfunction

  function automatic bit exp_fast(input logic [15:0] w, input logic dbl);
    longint lhs = longint'(eff_inc(w, dbl)) * 200_000_000;
    return lhs > (longint'(30_000_000) * 4096);
  endfunction

  int m_acc = 0;
  bit m_ph = 0, m_l = 0, m_s = 0;
  always @(posedge clk or negedge rst_n) begin : model
    int sum;
    bit clr, nsclk;
    if (!rst_n) begin
      m_acc <= 0; m_ph <= 0; m_l <= 0; m_s <= 0;
    end else begin
      sum = m_acc + eff_inc(freq_word, double_rate);
      clr = start && acc_clear_on_start;
      nsclk = !m_ph ^ cpol;
      m_l <= 0; m_s <= 0;
      if (clr) m_acc <= 0;
      else if (enable) m_acc <= (sum >= 2048) ? sum - 2048 : sum;
      if (!enable) m_ph <= 0;
      else if (!clr && sum >= 2048) begin
        m_ph <= !m_ph;
        m_l  <= (nsclk == launch_rise);
        m_s  <= (nsclk == latch_rise);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R2 sclk", sclk, m_ph ^ cpol);
    chk("R4 launch_stb", launch_stb, m_l);
    chk("R4 sample_stb", sample_stb, m_s);
    chk("R8 fast_path", fast_path, exp_fast(freq_word, double_rate));
    if (sclk !== prev_sclk) toggles++;
    prev_sclk = sclk;
  endtask

  task automatic clear_start();
    start = 1; acc_clear_on_start = 1;
    step();
    start = 0; acc_clear_on_start = 0;
  endtask

  task automatic count_run(input string req, input int cyc, input int exp_t);
    toggles = 0;
    repeat (cyc) step();
    checks++;
    if (toggles != exp_t) begin
      errors++;
      $display("FAIL %s: actual %0d toggles expected %0d", req, toggles, exp_t);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sclk", sclk, cpol);
    chk("R1 launch_stb", launch_stb, 1'b0);
    chk("R1 sample_stb", sample_stb, 1'b0);
    rst_n = 1;
    step(); prev_sclk = sclk;

    // R3 full rate
    freq_word = 16'd2048; enable = 1;
    count_run("R3 full rate", 8, 8);
    // R3 quarter rate from zero
    enable = 0; step(); step();
    freq_word = 16'd512; clear_start(); enable = 1; step();
    count_run("R3 quarter rate", 16, 4);
    // R7 doubled
    double_rate = 1;
    count_run("R7 double rate", 16, 8);
    // R2 clamp above 2048
    double_rate = 0; freq_word = 16'd5000;
    count_run("R2 clamp", 8, 8);
    // R5 idle with cpol high
    enable = 0; cpol = 1; step();
    count_run("R5 idle", 6, 0);
    chk("R5 idle level", sclk, 1'b1);
    chk("R5 no launch", launch_stb, 1'b0);
    // R6 start without clear has no effect; with clear restarts phase
    cpol = 0; freq_word = 16'd1024; enable = 1; step();
    start = 1; step(); start = 0;
    clear_start();
    count_run("R6 clear restart", 2, 1);
    // R4 both strobes on same edge
    launch_rise = 1; latch_rise = 1; freq_word = 16'd2048;
    repeat (8) step();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) begin
        enable = 0;
        step();
        cpol = 1'($urandom_range(0, 1));
      end else enable = 1;
      start = (r >= 90);
      acc_clear_on_start = 1'($urandom_range(0, 1));
      if (r >= 85 && r < 88) freq_word = 16'($urandom_range(1900, 2100));
      if (r == 88) freq_word = 16'($urandom_range(1, 800));
      if (r == 89) double_rate = ~double_rate;
      if (r == 4) begin
        launch_rise = 1'($urandom_range(0, 1));
        latch_rise  = 1'($urandom_range(0, 1));
      end
      step();
    end
    start = 0;
    step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule